// File: doc/BRIEF.md
# Strap-Aware PLL Frequency Calculator

A sequential arithmetic block that works out the main PLL output frequency and the peripheral bus clock frequency, both in Hz, from three 32-bit words: the PLL parameter word, the clock-select word and the hardware strap word. A one-cycle start pulse captures the inputs and launches the computation. A one-cycle done pulse marks the moment both results are valid. The results then stay on the outputs until the next computation completes.

The reference clock is picked from the strap word. The PLL multiplier comes from three packed fields, with an integer truncation after each division. The multiplier can be forced to zero by an off bit, or to one by a bypass bit. The bus clock is the PLL output divided by a programmable divider field plus one, and then by a fixed divider. All four divisions share one restoring divider that produces one quotient bit per cycle. A multiply takes one cycle. No combinational divider is used.

Top module: `pll_freq_calc`

## Requirements
- R1: The reference frequency is 25,000,000 Hz when strap bit 23 is 1. When strap bit 23 is 0 and strap bit 24 is 1, it is 48,000,000 Hz. When both bits are 0, it is 24,000,000 Hz.
- R2: When bit 19 of the PLL parameter word is 1, both results are 0, whatever the other bits are (bypass included).
- R3: When bit 19 is 0 and bit 20 is 1, the PLL result equals the reference frequency.
- R4: When bits 19 and 20 are both 0, the fields are m = param[12:5], n = param[4:0] and p = param[18:13]. The multiplier is floor(floor((m+1)/(n+1))/(p+1)). The PLL result is the reference frequency times the multiplier, truncated to 32 bits.
- R5: The bus result is floor(floor(pll/(d+1))/4), where d = clk_sel[25:23].
- R6: A start pulse that arrives while busy_o is high is ignored. The running computation finishes with the inputs it captured, and no second computation follows.
- R7: done_o is high for exactly one cycle per accepted start. busy_o is low in the cycle done_o is high, so a start in that cycle is accepted.
- R8: After reset, busy_o and done_o are 0 and both results are 0.
- R9: The results change only in the cycle done_o is high, and they hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; inputs are captured when idle |
| pll_param_i | input | 32 | PLL parameter word (off, bypass, p, m, n) |
| clk_sel_i | input | 32 | Clock-select word carrying the bus divider field |
| strap_i | input | 32 | Hardware strap word carrying the reference select bits |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse: results valid |
| pll_hz_o | output | 32 | PLL output frequency in Hz |
| bus_hz_o | output | 32 | Bus clock frequency in Hz |

## Verification
A start request can fall in the same cycle as the completion of an earlier computation, or in the middle of one. The bench provokes the first case by raising start_i in the cycle done_o is seen, and expects a second, complete computation with the new inputs. It provokes the second case by raising start_i with a different parameter word while busy_o is high. There it expects the first word's results and an idle cycle after done_o. The main function is swept over every n, a spread of m and p values, all strap combinations and all bus divider values. Every result is compared with integer arithmetic done in the bench.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV1,
    ST_DIV2,
    ST_MUL,
    ST_DIV3,
    ST_DIV4
  } calc_st_e;
endpackage

// File: rtl/pll_refclk_sel.sv
module pll_refclk_sel #(
  parameter int unsigned SW     = 32,
  parameter int unsigned S25_BIT = 23,
  parameter int unsigned S48_BIT = 24,
  parameter int unsigned HZ_25  = 25000000,
  parameter int unsigned HZ_48  = 48000000,
  parameter int unsigned HZ_24  = 24000000
) (
  input  logic [SW-1:0] strap_i,
  output logic [31:0]   ref_hz_o
);
  // 25 MHz strap wins over 48 MHz strap
  always_comb begin
    if (strap_i[S25_BIT])      ref_hz_o = HZ_25;
    else if (strap_i[S48_BIT]) ref_hz_o = HZ_48;
    else                       ref_hz_o = HZ_24;
  end
endmodule

// File: rtl/pll_serial_div.sv
module pll_serial_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quo_o,
  output logic         done_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    shifted, diff;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, den_q};
  assign quo_o   = quo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        quo_q <= num_i;
        rem_q <= '0;
        den_q <= den_i;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (!diff[W]) begin
          rem_q <= diff[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  // R4: the final remainder is below the divisor, so the quotient is the floor
  p_rem_below_den_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rem_q < den_q));
  // R4: no new division is launched while one is running
  p_no_overlap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !run_q);
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pll_calc_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter int unsigned N_LSB    = 0,
  parameter int unsigned N_W      = 5,
  parameter int unsigned M_LSB    = 5,
  parameter int unsigned M_W      = 8,
  parameter int unsigned P_LSB    = 13,
  parameter int unsigned P_W      = 6,
  parameter int unsigned OFF_BIT  = 19,
  parameter int unsigned BYP_BIT  = 20,
  parameter int unsigned PDIV_LSB = 23,
  parameter int unsigned PDIV_W   = 3,
  parameter int unsigned BUS_DIV  = 4,
  parameter int unsigned S25_BIT  = 23,
  parameter int unsigned S48_BIT  = 24
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] pll_param_i,
  input  logic [31:0] clk_sel_i,
  input  logic [31:0] strap_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [31:0] pll_hz_o,
  output logic [31:0] bus_hz_o
);
  calc_st_e          st_q;
  logic [W-1:0]      num_q, den_q, mult_q, pll_q, clkin_q;
  logic [P_W-1:0]    p_q;
  logic [PDIV_W-1:0] pdiv_q;
  logic              off_q, byp_q, go_q;
  logic [31:0]       ref_hz;
  logic [W-1:0]      dv_quo;
  logic              dv_done;

  pll_refclk_sel #(.SW(32), .S25_BIT(S25_BIT), .S48_BIT(S48_BIT)) u_ref (
    .strap_i (strap_i),
    .ref_hz_o(ref_hz)
  );

  pll_serial_div #(.W(W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (go_q),
    .num_i (num_q),
    .den_i (den_q),
    .quo_o (dv_quo),
    .done_o(dv_done)
  );

  assign busy_o = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      num_q    <= '0;
      den_q    <= '0;
      mult_q   <= '0;
      pll_q    <= '0;
      clkin_q  <= '0;
      p_q      <= '0;
      pdiv_q   <= '0;
      off_q    <= 1'b0;
      byp_q    <= 1'b0;
      go_q     <= 1'b0;
      done_o   <= 1'b0;
      pll_hz_o <= '0;
      bus_hz_o <= '0;
    end else begin
      go_q   <= 1'b0;
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          clkin_q <= W'(ref_hz);
          p_q     <= pll_param_i[P_LSB +: P_W];
          pdiv_q  <= clk_sel_i[PDIV_LSB +: PDIV_W];
          off_q   <= pll_param_i[OFF_BIT];
          byp_q   <= pll_param_i[BYP_BIT];
          if (pll_param_i[OFF_BIT]) begin
            mult_q <= '0;
            st_q   <= ST_MUL;
          end else if (pll_param_i[BYP_BIT]) begin
            mult_q <= W'(1);
            st_q   <= ST_MUL;
          end else begin
            num_q <= W'(pll_param_i[M_LSB +: M_W]) + W'(1);
            den_q <= W'(pll_param_i[N_LSB +: N_W]) + W'(1);
            go_q  <= 1'b1;
            st_q  <= ST_DIV1;
          end
        end
        ST_DIV1: if (dv_done) begin
          num_q <= dv_quo;
          den_q <= W'(p_q) + W'(1);
          go_q  <= 1'b1;
          st_q  <= ST_DIV2;
        end
        ST_DIV2: if (dv_done) begin
          mult_q <= dv_quo;
          st_q   <= ST_MUL;
        end
        ST_MUL: begin
          pll_q <= clkin_q * mult_q;
          num_q <= clkin_q * mult_q;
          den_q <= W'(pdiv_q) + W'(1);
          go_q  <= 1'b1;
          st_q  <= ST_DIV3;
        end
        ST_DIV3: if (dv_done) begin
          num_q <= dv_quo;
          den_q <= W'(BUS_DIV);
          go_q  <= 1'b1;
          st_q  <= ST_DIV4;
        end
        ST_DIV4: if (dv_done) begin
          pll_hz_o <= 32'(pll_q);
          bus_hz_o <= 32'(dv_quo);
          done_o   <= 1'b1;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_ignore_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(clkin_q) && $stable(p_q) && $stable(pdiv_q) && $stable(off_q)));
  p_hold_pll_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pll_hz_o) |-> done_o);
  p_hold_bus_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bus_hz_o) |-> done_o);
  p_off_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && off_q) |-> (pll_hz_o == 32'd0 && bus_hz_o == 32'd0));
  p_bypass_ref_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && byp_q && !off_q) |-> (pll_hz_o == 32'(clkin_q)));
  p_bus_le_pll_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bus_hz_o <= pll_hz_o));
endmodule

// File: tb/sim_pll_freq_calc.sv
module sim_pll_freq_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] prm = '0, sel = '0, str = '0;
  logic        busy, done;
  logic [31:0] pll_hz, bus_hz;
  int          n_tests = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  pll_freq_calc u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .pll_param_i(prm), .clk_sel_i(sel), .strap_i(str),
    .busy_o(busy), .done_o(done), .pll_hz_o(pll_hz), .bus_hz_o(bus_hz)
  );

  function automatic logic [31:0] ref_f(input logic [31:0] s);
    if (s[23]) return 32'd25000000;
    if (s[24]) return 32'd48000000;
    return 32'd24000000;
  endfunction

  function automatic logic [31:0] pll_f(input logic [31:0] p, input logic [31:0] s);
    logic [31:0] mult;
    if (p[19]) return 32'd0;
    if (p[20]) mult = 32'd1;
    else mult = ((32'(p[12:5]) + 32'd1) / (32'(p[4:0]) + 32'd1)) / (32'(p[18:13]) + 32'd1);
    return ref_f(s) * mult;
  endfunction

  function automatic logic [31:0] bus_f(input logic [31:0] pll, input logic [31:0] c);
    return (pll / (32'(c[25:23]) + 32'd1)) / 32'd4;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run_calc(input logic [31:0] p, input logic [31:0] c, input logic [31:0] s,
                          input string tag);
    logic [31:0] ep, eb;
    ep = pll_f(p, s);
    eb = bus_f(ep, c);
    @(negedge clk);
    prm = p; sel = c; str = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(pll_hz == ep, {tag, " pll"}, pll_hz, ep);
    chk(bus_hz == eb, {tag, " bus (R5)"}, bus_hz, eb);
    chk(busy == 1'b0, "R7 idle at done", 32'(busy), 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R7 single pulse", 32'(done), 32'd0);
  endtask

  initial begin
    logic [31:0] ms [4] = '{0, 9, 200, 255};
    logic [31:0] ps [3] = '{0, 2, 63};
    logic [31:0] straps [4] = '{32'h0, 32'h0100_0000, 32'h0080_0000, 32'h0180_0000};
    logic [31:0] ep, eb, p0, hold_p, hold_b;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(busy == 1'b0, "R8 busy", 32'(busy), 0);
    chk(done == 1'b0, "R8 done", 32'(done), 0);
    chk(pll_hz == 0, "R8 pll", pll_hz, 0);
    chk(bus_hz == 0, "R8 bus", bus_hz, 0);
    rst_n = 1'b1;

    // R1/R3: reference selection via bypass, every strap combination
    for (int i = 0; i < 4; i++) run_calc(32'h0010_0000, 32'h0, straps[i], "R1 R3 bypass");
    // R2: off, alone and with bypass and busy fields
    run_calc(32'h0008_0000, 32'h0, 32'h0, "R2 off");
    run_calc(32'h001F_FFFF, 32'h0380_0000, 32'h0080_0000, "R2 off+bypass");
    // R5: all bus divider values
    for (int d = 0; d < 8; d++) run_calc(32'h0010_0000, 32'(d) << 23, straps[d % 4], "R5 divider");
    // R4: sweep of n, m, p
    for (int n = 0; n < 32; n++)
      for (int mi = 0; mi < 4; mi++)
        for (int pi = 0; pi < 3; pi++)
          run_calc((ps[pi] << 13) | (ms[mi] << 5) | 32'(n), 32'(n % 8) << 23,
                   straps[(n + mi) % 4], "R4 sweep");

    // R6: start while busy is ignored
    p0 = (32'd0 << 13) | (32'd255 << 5) | 32'd3;
    ep = pll_f(p0, 32'h0);
    eb = bus_f(ep, 32'h0080_0000);
    @(negedge clk);
    prm = p0; sel = 32'h0080_0000; str = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R6 busy mid-run", 32'(busy), 1);
    prm = 32'h0008_0000; sel = 32'h0; str = 32'h0080_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(pll_hz == ep, "R6 first pll kept", pll_hz, ep);
    chk(bus_hz == eb, "R6 first bus kept", bus_hz, eb);
    @(negedge clk);
    chk(busy == 1'b0, "R6 no second run", 32'(busy), 0);

    // R7: start in the done cycle is accepted
    ep = pll_f(32'h0010_0000, 32'h0100_0000);
    @(negedge clk);
    prm = 32'h0008_0000; sel = 32'h0; str = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    prm = 32'h0010_0000; str = 32'h0100_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 start at done accepted", 32'(busy), 1);
    wait_done();
    chk(pll_hz == ep, "R7 back-to-back pll", pll_hz, ep);

    // R9: results hold while idle and through a running computation
    hold_p = pll_hz; hold_b = bus_hz;
    @(negedge clk);
    prm = 32'h0008_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    chk(pll_hz == hold_p, "R9 pll hold", pll_hz, hold_p);
    chk(bus_hz == hold_b, "R9 bus hold", bus_hz, hold_b);
    wait_done();
    chk(pll_hz == 0, "R9 updated at done", pll_hz, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule